// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block sits beside one processor and decides which single interrupt that processor is shown. A source controller offers interrupts to it, each as a 24-bit source number with an 8-bit priority. Lower numbers are more favoured, and all ones means the least favoured level or that nothing is pending. The block keeps a 32-bit presentation register. Its top byte is the processor's current priority and its low 24 bits are the pending source number, where zero means empty. Beside it the block keeps the priority of the pending source and a priority register for a software inter-processor interrupt (IPI). The IPI always uses source number 2.

Each offer is either presented, which raises the interrupt line, or bounced back to the source controller as a reject. A better offer displaces a source already pending, and the displaced source is bounced. The processor drives a command port with four operations: accept (read and take the pending source), end-of-interrupt, write current priority and write IPI priority. Commands complete in one clock. The block tells the source controller about rejects, end-of-interrupts and resend requests with single-cycle pulses.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the interrupt line is low, no notification pulse is active, the presentation register reads 0 (current priority 0, nothing pending), and the pending and IPI priorities are 0xFF.
- R2: An offer whose priority is not strictly below the current priority is refused. A reject carrying its source number is pulsed and the block state does not change.
- R3: An offer is also refused, with a reject of its own number, when a source is pending whose priority is less than or equal to the offered one.
- R4: An offer that is not refused is latched as the pending source and priority, and the line is raised. A source that was pending before is rejected in the same cycle.
- R5: Accept (opcode 0) returns the old 32-bit presentation register on the response port and lowers the line. The register then holds the old pending priority in bits 31:24 and zero in bits 23:0, and the pending priority becomes 0xFF.
- R6: Writing the current priority (opcode 2, value in data bits 7:0) with a strictly more favoured value withdraws any pending source whose priority is greater than or equal to the new value. The source is rejected, the pending priority goes to 0xFF and the line goes low.
- R7: Writing the current priority with an equal or less favoured value performs a resend. When the IPI priority is below the new current priority, the IPI check of R8 runs first. A resend request pulse is then always issued.
- R8: Writing the IPI priority (opcode 3, value in data bits 7:0) with a value below the current priority runs the IPI check. The check does nothing when a pending source has a priority less than or equal to the IPI priority. Otherwise it rejects any pending source, latches source 2 with the IPI priority, and raises the line.
- R9: End-of-interrupt (opcode 1) copies data bits 31:24 into the current priority and pulses an EOI carrying data bits 23:0. It then performs a resend as in R7.
- R10: A command has precedence over an offer. In a command cycle the offer-ready output is low and the offer has no effect.
- R11: Reject, EOI, resend and response pulses appear in the cycle after the operation that causes them and last one cycle. A cycle with no command and no offer produces none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| offer_valid | input | 1 | An interrupt is offered this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_ready | output | 1 | Offer is considered this cycle (no command present) |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 accept, 1 end-of-interrupt, 2 write current priority, 3 write IPI priority |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Accept response valid |
| rsp_data | output | 32 | Presentation register returned by accept |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source controller |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source number being ended |
| resend_req | output | 1 | Request that the source controller resend refused sources |

## Verification
The bench sweeps several current priorities against a set of pending states, from empty to pending at priorities both more and less favoured. Each combination is met with offers whose priorities fall on both sides of, and exactly on, the current and pending levels, so the strict-versus-equal comparisons in R2, R3 and R6 are told apart. Each sequence continues with an IPI priority write, an accept and an end-of-interrupt. These steps separate an IPI that displaces a source from one that is blocked or never checked. They also show that accept carries the pending priority into the current priority. A directed collision of an offer with a command shows that the command wins.

// File: rtl/irq_present_pkg.sv
package irq_present_pkg;

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_EOI      = 2'd1,
        OP_SET_CPRI = 2'd2,
        OP_SET_IPI  = 2'd3
    } ipc_op_e;

endpackage

// File: rtl/ipc_offer_judge.sv
module ipc_offer_judge #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] offer_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              win
);
    logic below_cur;
    logic blocked;

    always_comb begin
        below_cur = offer_prio < cur_prio;
        blocked   = (pend_src != '0) && (pend_prio <= offer_prio);
        win       = below_cur && !blocked;
    end
endmodule

// File: rtl/ipc_ipi_check.sv
module ipc_ipi_check #(
    parameter int SRC_W  = 24,
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              fire
);
    logic eligible;
    logic held_off;

    always_comb begin
        eligible = ipi_prio < cur_prio;
        held_off = (pend_src != '0) && (pend_prio <= ipi_prio);
        fire     = eligible && !held_off;
    end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
    import irq_present_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     offer_valid,
    input  logic [SRC_W-1:0]         offer_src,
    input  logic [PRIO_W-1:0]        offer_prio,
    output logic                     offer_ready,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [SRC_W+PRIO_W-1:0]  cmd_data,
    output logic                     rsp_valid,
    output logic [SRC_W+PRIO_W-1:0]  rsp_data,
    output logic                     irq_out,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_req
);
    localparam int REG_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] NO_PRIO = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  IPI_ID  = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [REG_W-1:0]  pres;
        logic [PRIO_W-1:0] pend;
        logic [PRIO_W-1:0] ipi;
        logic              irq;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_id;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_id;
        logic              resend;
        logic              rsp_v;
        logic [REG_W-1:0]  rsp;
    } state_t;

    state_t st_d, st_q;

    logic [PRIO_W-1:0] cur_cpri;
    logic [SRC_W-1:0]  cur_src;
    logic [PRIO_W-1:0] chk_cpri_d;
    logic [PRIO_W-1:0] chk_ipi_d;
    logic              ipi_fire;
    logic              offer_win;
    ipc_op_e           op;

    assign cur_cpri = st_q.pres[REG_W-1 -: PRIO_W];
    assign cur_src  = st_q.pres[SRC_W-1:0];
    assign op       = ipc_op_e'(cmd_op);

    // Operands for the IPI check: the priority levels as they stand after
    // the command's own register update.
    always_comb begin
        chk_cpri_d = cur_cpri;
        chk_ipi_d  = st_q.ipi;
        unique case (op)
            OP_EOI:      chk_cpri_d = cmd_data[REG_W-1 -: PRIO_W];
            OP_SET_CPRI: chk_cpri_d = cmd_data[PRIO_W-1:0];
            OP_SET_IPI:  chk_ipi_d  = cmd_data[PRIO_W-1:0];
            default:     ;
        endcase
    end

    ipc_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
        .ipi_prio  (chk_ipi_d),
        .cur_prio  (chk_cpri_d),
        .pend_src  (cur_src),
        .pend_prio (st_q.pend),
        .fire      (ipi_fire)
    );

    ipc_offer_judge #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_judge (
        .offer_prio (offer_prio),
        .cur_prio   (cur_cpri),
        .pend_src   (cur_src),
        .pend_prio  (st_q.pend),
        .win        (offer_win)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rej_v  = 1'b0;
        st_d.rej_id = '0;
        st_d.eoi_v  = 1'b0;
        st_d.eoi_id = '0;
        st_d.resend = 1'b0;
        st_d.rsp_v  = 1'b0;
        st_d.rsp    = '0;

        if (cmd_valid) begin
            unique case (op)
                OP_ACCEPT: begin
                    st_d.rsp_v = 1'b1;
                    st_d.rsp   = st_q.pres;
                    st_d.irq   = 1'b0;
                    st_d.pres  = {st_q.pend, {SRC_W{1'b0}}};
                    st_d.pend  = NO_PRIO;
                end
                OP_EOI: begin
                    st_d.pres[REG_W-1 -: PRIO_W] = chk_cpri_d;
                    st_d.eoi_v  = 1'b1;
                    st_d.eoi_id = cmd_data[SRC_W-1:0];
                    st_d.resend = 1'b1;
                end
                OP_SET_CPRI: begin
                    st_d.pres[REG_W-1 -: PRIO_W] = chk_cpri_d;
                    if (chk_cpri_d < cur_cpri) begin
                        if ((cur_src != '0) && (chk_cpri_d <= st_q.pend)) begin
                            st_d.rej_v  = 1'b1;
                            st_d.rej_id = cur_src;
                            st_d.pres[SRC_W-1:0] = '0;
                            st_d.pend   = NO_PRIO;
                            st_d.irq    = 1'b0;
                        end
                    end else begin
                        st_d.resend = 1'b1;
                    end
                end
                default: begin
                    st_d.ipi = chk_ipi_d;
                end
            endcase

            // IPI check shared by the resend paths and the IPI write
            if (ipi_fire && (op != OP_ACCEPT) &&
                !((op == OP_SET_CPRI) && (chk_cpri_d < cur_cpri))) begin
                if (cur_src != '0) begin
                    st_d.rej_v  = 1'b1;
                    st_d.rej_id = cur_src;
                end
                st_d.pres[SRC_W-1:0] = IPI_ID;
                st_d.pend = chk_ipi_d;
                st_d.irq  = 1'b1;
            end
        end else if (offer_valid) begin
            st_d.rej_v = 1'b1;
            if (offer_win) begin
                st_d.rej_id = cur_src;
                st_d.rej_v  = cur_src != '0;
                st_d.pres[SRC_W-1:0] = offer_src;
                st_d.pend = offer_prio;
                st_d.irq  = 1'b1;
            end else begin
                st_d.rej_id = offer_src;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pend <= NO_PRIO;
            st_q.ipi  <= NO_PRIO;
        end else begin
            st_q <= st_d;
        end
    end

    assign offer_ready = !cmd_valid;
    assign rsp_valid   = st_q.rsp_v;
    assign rsp_data    = st_q.rsp;
    assign irq_out     = st_q.irq;
    assign rej_valid   = st_q.rej_v;
    assign rej_src     = st_q.rej_id;
    assign eoi_valid   = st_q.eoi_v;
    assign eoi_src     = st_q.eoi_id;
    assign resend_req  = st_q.resend;
endmodule

// File: rtl/irq_present_ctrl_chk.sv
module irq_present_ctrl_chk #(
    parameter int SRC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             offer_valid,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [SRC_W-1:0] cmd_low,
    input logic             irq_out,
    input logic             rej_valid,
    input logic             eoi_valid,
    input logic [SRC_W-1:0] eoi_src,
    input logic             resend_req,
    input logic             rsp_valid
);
    // R5: accept takes the line down and answers the next cycle
    a_r5_accept_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> (!irq_out && rsp_valid));

    // R9: end-of-interrupt forwards its source and requests a resend
    a_r9_eoi_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=> (eoi_valid && resend_req && eoi_src == $past(cmd_low)));

    // R2, R4: a considered offer is either bounced or presented
    a_r4_offer_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !cmd_valid) |=> (rej_valid || irq_out));

    // R11: an idle cycle produces no pulse
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!offer_valid && !cmd_valid) |=> !(rej_valid || eoi_valid || resend_req || rsp_valid));

    // R8: the IPI priority write never produces an EOI, resend or response
    a_r8_ipi_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> !(eoi_valid || resend_req || rsp_valid));
endmodule

bind irq_present_ctrl irq_present_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .offer_valid (offer_valid),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_low     (cmd_data[SRC_W-1:0]),
    .irq_out     (irq_out),
    .rej_valid   (rej_valid),
    .eoi_valid   (eoi_valid),
    .eoi_src     (eoi_src),
    .resend_req  (resend_req),
    .rsp_valid   (rsp_valid)
);

// File: tb/irq_present_ctrl_bench.sv
`timescale 1ns/1ps
module irq_present_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        offer_ready;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_present_ctrl u_irq_present_ctrl (.*);

    // reference model state
    logic [7:0]  m_cpri, m_pend, m_ipi;
    logic [23:0] m_src;
    bit          m_irq;
    bit          e_rej_v, e_eoi_v, e_res, e_rsp_v;
    logic [23:0] e_rej, e_eoi;
    logic [31:0] e_rsp;

    task automatic model_reset();
        m_cpri = 8'h00; m_src = '0; m_pend = 8'hFF; m_ipi = 8'hFF; m_irq = 0;
    endtask

    task automatic model_ipi(input logic [7:0] cp);
        if (m_ipi < cp && !(m_src != 0 && m_pend <= m_ipi)) begin
            if (m_src != 0) begin e_rej_v = 1; e_rej = m_src; end
            m_src = 24'd2; m_pend = m_ipi; m_irq = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic step(input string tag, input bit ov, input logic [23:0] os,
                        input logic [7:0] opr, input bit cv, input logic [1:0] cop,
                        input logic [31:0] cd);
        logic [7:0] nc;
        @(negedge clk);
        offer_valid = ov; offer_src = os; offer_prio = opr;
        cmd_valid = cv; cmd_op = cop; cmd_data = cd;
        e_rej_v = 0; e_rej = 0; e_eoi_v = 0; e_eoi = 0; e_res = 0; e_rsp_v = 0; e_rsp = 0;
        #1;
        tests++;
        if (offer_ready !== !cv) begin
            fails++;
            $display("FAIL %s offer_ready: got %0b expected %0b", tag, offer_ready, !cv);
        end
        if (cv) begin
            case (cop)
                2'd0: begin
                    e_rsp_v = 1; e_rsp = {m_cpri, m_src};
                    m_irq = 0; m_cpri = m_pend; m_src = 0; m_pend = 8'hFF;
                end
                2'd1: begin
                    m_cpri = cd[31:24]; e_eoi_v = 1; e_eoi = cd[23:0];
                    model_ipi(m_cpri); e_res = 1;
                end
                2'd2: begin
                    nc = cd[7:0];
                    if (nc < m_cpri) begin
                        m_cpri = nc;
                        if (m_src != 0 && nc <= m_pend) begin
                            e_rej_v = 1; e_rej = m_src; m_src = 0; m_pend = 8'hFF; m_irq = 0;
                        end
                    end else begin
                        m_cpri = nc; model_ipi(m_cpri); e_res = 1;
                    end
                end
                default: begin
                    m_ipi = cd[7:0];
                    model_ipi(m_cpri);
                end
            endcase
        end else if (ov) begin
            if (opr >= m_cpri || (m_src != 0 && m_pend <= opr)) begin
                e_rej_v = 1; e_rej = os;
            end else begin
                if (m_src != 0) begin e_rej_v = 1; e_rej = m_src; end
                m_src = os; m_pend = opr; m_irq = 1;
            end
        end
        @(posedge clk);
        #1;
        offer_valid = 0; cmd_valid = 0;
        tests++;
        if (irq_out !== m_irq || rej_valid !== e_rej_v || (e_rej_v && rej_src !== e_rej) ||
            eoi_valid !== e_eoi_v || (e_eoi_v && eoi_src !== e_eoi) || resend_req !== e_res ||
            rsp_valid !== e_rsp_v || (e_rsp_v && rsp_data !== e_rsp)) begin
            fails++;
            $display("FAIL %s got irq=%0b rej=%0b/%h eoi=%0b/%h res=%0b rsp=%0b/%h expected irq=%0b rej=%0b/%h eoi=%0b/%h res=%0b rsp=%0b/%h",
                     tag, irq_out, rej_valid, rej_src, eoi_valid, eoi_src, resend_req, rsp_valid, rsp_data,
                     m_irq, e_rej_v, e_rej, e_eoi_v, e_eoi, e_res, e_rsp_v, e_rsp);
        end
    endtask

    logic [7:0] cpri_set [4] = '{8'h00, 8'h10, 8'h80, 8'hFF};
    logic [7:0] pend_set [5] = '{8'h03, 8'h10, 8'h40, 8'hFE, 8'hFF};
    logic [7:0] offr_set [9] = '{8'h00, 8'h02, 8'h0F, 8'h10, 8'h3F, 8'h40, 8'h7F, 8'h80, 8'hFE};

    initial begin
        model_reset();
        do_reset();
        // R1: reset state at the ports
        #1;
        tests++;
        if (irq_out !== 0 || rej_valid !== 0 || eoi_valid !== 0 || resend_req !== 0 ||
            rsp_valid !== 0 || offer_ready !== 1) begin
            fails++;
            $display("FAIL R1 reset outputs: irq=%0b rej=%0b eoi=%0b res=%0b rsp=%0b rdy=%0b expected 0 0 0 0 0 1",
                     irq_out, rej_valid, eoi_valid, resend_req, rsp_valid, offer_ready);
        end
        step("R1", 0, 0, 0, 1, 2'd0, 32'h0);              // accept reads zero register
        step("R11", 0, 0, 0, 0, 2'd0, 32'h0);             // idle: no pulses

        // R10: offer colliding with a command is ignored
        do_reset();
        step("R7", 0, 0, 0, 1, 2'd2, 32'h80);
        step("R10", 1, 24'h77, 8'h05, 1, 2'd2, 32'h90);
        step("R10", 0, 0, 0, 1, 2'd0, 32'h0);             // nothing pending was latched

        // sweep
        foreach (cpri_set[ci]) begin
            foreach (pend_set[pi]) begin
                foreach (offr_set[oi]) begin
                    do_reset();
                    step("R7", 0, 0, 0, 1, 2'd2, 32'h0000_00FF);
                    if (pend_set[pi] != 8'hFF)
                        step("R4", 1, 24'h000123, pend_set[pi], 0, 2'd0, 0);
                    step("R6", 0, 0, 0, 1, 2'd2, {24'h0, cpri_set[ci]});
                    step("R3", 1, 24'h000456, offr_set[oi], 0, 2'd0, 0);
                    step("R2", 1, 24'h000789, offr_set[oi], 0, 2'd0, 0);
                    step("R8", 0, 0, 0, 1, 2'd3, {24'h0, offr_set[oi] ^ 8'h21});
                    step("R5", 0, 0, 0, 1, 2'd0, 0);
                    step("R9", 0, 0, 0, 1, 2'd1, {cpri_set[ci] ^ 8'h44, 24'h000456});
                    step("R11", 0, 0, 0, 0, 2'd0, 0);
                end
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule